// File: doc/BRIEF.md
# Serial Clock-Configuration Register Bank

This block receives the configuration writes for a clock generator. A two-wire serial slave in front of it does the bit-level work and hands over whole bytes, most significant bit received first in `byte_val[7]`. Along with them come single-cycle flags for a start condition (first or repeated) and a stop condition. The bank counts the bytes of each transfer. It checks the first byte against a fixed device address and drops the next two bytes, which carry command and count. It then loads up to six control registers from the data bytes that follow. Any data bytes after that are accepted on the bus but have no effect.

Register 0 holds the frequency-source choice, a four-bit serial frequency select and a two-bit operating mode. The mode can be normal, spread spectrum or all outputs high-impedance. Registers 1 to 5 hold one run/hold-low bit for each clock output. From these the block produces a run enable and an output enable per output. High-impedance mode overrides every individual gate bit.

Top module: `cfg_serial_regbank`

## Requirements
- R1: A synchronous active-high reset sets register 0 to 0x00. It sets every implemented gate bit in registers 1 to 5 to 1 and every reserved bit to 0, so `reg_q` becomes 0xFFFFFF7F0F00.
- R2: Data is loaded only when the first byte after a start equals 0xD2. Any other value leaves all registers unchanged for the whole transfer.
- R3: Sequence bytes 2 and 3 of a transfer are not stored. Sequence byte 4+k (k = 0..5) loads register k, found at `reg_q[8k+7:8k]`. The new value shows at the outputs after the clock edge that samples the strobe.
- R4: Sequence byte 10 and every later byte of the same transfer are ignored, however long the transfer runs. The byte counter does not wrap.
- R5: Reserved bits always read 0, whatever is written. These are register 0 bit 7, register 1 bits 7:4 and register 2 bit 7.
- R6: Register 0 bits 1:0 set the mode. 00 is normal. 10 gives `spread_en`=1. 11 is high impedance, where every `out_en` and `clk_run` bit is 0. 01 behaves as normal.
- R7: `use_serial_sel` equals register 0 bit 3. `freq_sel` is {register 0 bit 2, register 0 bits 6:4}.
- R8: Outside high-impedance mode, `clk_run[8(k-1)+j]` equals bit j of register k (k = 1..5). `out_en` is 1 exactly on the implemented gate bits: 0x0F for register 1, 0x7F for register 2 and 0xFF for registers 3 to 5.
- R9: A stop ends loading. Registers written before it keep their new values, and strobes after it are ignored until the next start.
- R10: A repeated start in the middle of a transfer ends loading and begins a fresh transfer, which again needs the address byte.
- R11: A byte strobe in the same cycle as a start or stop flag is dropped. Registers never change in a cycle without a byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: `byte_val` holds a received byte |
| byte_val | input | 8 | Received byte, bit 7 received first |
| frm_start | input | 1 | One-cycle flag: start or repeated start seen |
| frm_stop | input | 1 | One-cycle flag: stop seen |
| reg_q | output | 48 | Registers 0..5, register k in bits 8k+7:8k |
| use_serial_sel | output | 1 | 1: frequency from `freq_sel`; 0: from external select pins |
| freq_sel | output | 4 | Serial frequency select |
| mode | output | 2 | Operating mode field |
| spread_en | output | 1 | Spread spectrum active |
| clk_run | output | 40 | Per-output run (1) or hold low (0) |
| out_en | output | 40 | Per-output driver enable |

## Verification
Every register write shows at `reg_q` one clock edge after the cycle that carries the strobe. The mode, select, run and enable outputs decode those registers without another flop, so they are due on the same edge. The bench drives each byte on a falling edge and compares all outputs only after the last byte and the following rising edge, at the next falling edge. The framing cases (stop, repeated start, a flag coinciding with a byte, very long transfers) are judged by the register values that remain once the transfer is over.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int unsigned NUM_LIVE = 6;                 // registers that take data
    localparam int unsigned IDX_W    = $clog2(NUM_LIVE);
    localparam int unsigned REG_W    = NUM_LIVE * 8;
    localparam int unsigned GATE_W   = (NUM_LIVE - 1) * 8;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_SPREAD = 2'b10,
        MODE_HIZ    = 2'b11
    } mode_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_cmd_t;

    // Bits that may hold a 1 in register k.
    function automatic logic [7:0] wmask(int unsigned k);
        case (k)
            0:       return 8'h7F;
            1:       return 8'h0F;
            2:       return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    // Reset value: control register clear, gate bits running.
    function automatic logic [7:0] rst_val(int unsigned k);
        return (k == 0) ? 8'h00 : wmask(k);
    endfunction

endpackage

// File: rtl/cfg_frame_track.sv
module cfg_frame_track
    import cfg_regbank_pkg::*;
#(
    parameter logic [7:0]  DEV_ADDR       = 8'hD2,
    parameter int unsigned FIRST_DATA_SEQ = 4,
    parameter int unsigned SEQ_W          = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic [7:0] byte_val,
    input  logic       frm_start,
    input  logic       frm_stop,
    output wr_cmd_t    wr_cmd
);
    localparam logic [SEQ_W-1:0] SEQ_MAX  = {SEQ_W{1'b1}};
    localparam logic [SEQ_W-1:0] SEQ_BASE = SEQ_W'(FIRST_DATA_SEQ - 1);

    logic             active_q;
    logic             addr_ok_q;
    logic [SEQ_W-1:0] seq_q;     // bytes taken so far in this transfer
    logic             take;
    logic [SEQ_W-1:0] rel;

    assign take = byte_vld && active_q && !frm_start && !frm_stop;
    assign rel  = seq_q - SEQ_BASE;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            addr_ok_q <= 1'b0;
            seq_q     <= '0;
        end else if (frm_start) begin
            active_q  <= 1'b1;
            addr_ok_q <= 1'b0;
            seq_q     <= '0;
        end else if (frm_stop) begin
            active_q  <= 1'b0;
        end else if (take) begin
            if (seq_q == '0)
                addr_ok_q <= (byte_val == DEV_ADDR);
            if (seq_q != SEQ_MAX)
                seq_q <= seq_q + 1'b1;
        end
    end

    always_comb begin
        wr_cmd.en   = take && addr_ok_q && (seq_q >= SEQ_BASE)
                      && (rel < SEQ_W'(NUM_LIVE));
        wr_cmd.idx  = IDX_W'(rel);
        wr_cmd.data = byte_val;
    end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
    import cfg_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          wr_cmd,
    output logic [REG_W-1:0] reg_q
);
    for (genvar k = 0; k < NUM_LIVE; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                reg_q[8*k +: 8] <= rst_val(k);
            else if (wr_cmd.en && (wr_cmd.idx == IDX_W'(k)))
                reg_q[8*k +: 8] <= wr_cmd.data & wmask(k);
        end
    end

endmodule

// File: rtl/cfg_out_decode.sv
module cfg_out_decode
    import cfg_regbank_pkg::*;
(
    input  mode_e              mode_i,
    input  logic [GATE_W-1:0]  gate_i,
    output logic               spread_en,
    output logic [GATE_W-1:0]  clk_run,
    output logic [GATE_W-1:0]  out_en
);
    logic [GATE_W-1:0] impl;
    logic              hiz;

    for (genvar k = 1; k < NUM_LIVE; k++) begin : g_impl
        assign impl[8*(k-1) +: 8] = wmask(k);
    end

    assign hiz       = (mode_i == MODE_HIZ);
    assign spread_en = (mode_i == MODE_SPREAD);
    assign clk_run   = hiz ? '0 : gate_i;
    assign out_en    = hiz ? '0 : impl;

endmodule

// File: rtl/cfg_serial_regbank.sv
module cfg_serial_regbank
    import cfg_regbank_pkg::*;
#(
    parameter logic [7:0]  DEV_ADDR       = 8'hD2,
    parameter int unsigned FIRST_DATA_SEQ = 4,
    parameter int unsigned SEQ_W          = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_val,
    input  logic              frm_start,
    input  logic              frm_stop,
    output logic [REG_W-1:0]  reg_q,
    output logic              use_serial_sel,
    output logic [3:0]        freq_sel,
    output logic [1:0]        mode,
    output logic              spread_en,
    output logic [GATE_W-1:0] clk_run,
    output logic [GATE_W-1:0] out_en
);
    wr_cmd_t wr_cmd;
    mode_e   mode_w;

    cfg_frame_track #(
        .DEV_ADDR       (DEV_ADDR),
        .FIRST_DATA_SEQ (FIRST_DATA_SEQ),
        .SEQ_W          (SEQ_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val),
        .frm_start (frm_start),
        .frm_stop  (frm_stop),
        .wr_cmd    (wr_cmd)
    );

    cfg_reg_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_cmd (wr_cmd),
        .reg_q  (reg_q)
    );

    assign mode_w         = mode_e'(reg_q[1:0]);
    assign mode           = reg_q[1:0];
    assign use_serial_sel = reg_q[3];
    assign freq_sel       = {reg_q[2], reg_q[6:4]};

    cfg_out_decode u_dec (
        .mode_i    (mode_w),
        .gate_i    (reg_q[REG_W-1:8]),
        .spread_en (spread_en),
        .clk_run   (clk_run),
        .out_en    (out_en)
    );

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        byte_vld,
    input logic        frm_start,
    input logic        frm_stop,
    input logic [47:0] reg_q,
    input logic [39:0] clk_run,
    input logic [39:0] out_en
);
    localparam logic [47:0] DEF_Q   = 48'hFFFF_FF7F_0F00;
    localparam logic [39:0] IMPL_OE = 40'hFF_FFFF_7F0F;

    // R1
    p_reset_defaults_r1: assert property (@(posedge clk)
        rst |=> (reg_q == DEF_Q));

    // R5
    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_q[7] == 1'b0) && (reg_q[15:12] == 4'h0) && (reg_q[23] == 1'b0));

    // R6
    p_hiz_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_q[1:0] == 2'b11) |-> ((out_en == '0) && (clk_run == '0)));

    // R8
    p_outen_impl_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_q[1:0] != 2'b11) |-> ((out_en == IMPL_OE) && (clk_run == reg_q[47:8])));

    // R11
    p_flag_drops_byte_r11: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && (frm_start || frm_stop)) |=> $stable(reg_q));

    // R11
    p_no_strobe_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(reg_q));

endmodule

bind cfg_serial_regbank cfg_regbank_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .frm_start (frm_start),
    .frm_stop  (frm_stop),
    .reg_q     (reg_q),
    .clk_run   (clk_run),
    .out_en    (out_en)
);

// File: tb/cfg_serial_regbank_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_val = 8'h00;
    logic        frm_start = 1'b0;
    logic        frm_stop = 1'b0;
    logic [47:0] reg_q;
    logic        use_serial_sel;
    logic [3:0]  freq_sel;
    logic [1:0]  mode;
    logic        spread_en;
    logic [39:0] clk_run;
    logic [39:0] out_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] m [6];

    always #2.5 clk = ~clk;

    cfg_serial_regbank dut_i (
        .clk            (clk),
        .rst            (rst),
        .byte_vld       (byte_vld),
        .byte_val       (byte_val),
        .frm_start      (frm_start),
        .frm_stop       (frm_stop),
        .reg_q          (reg_q),
        .use_serial_sel (use_serial_sel),
        .freq_sel       (freq_sel),
        .mode           (mode),
        .spread_en      (spread_en),
        .clk_run        (clk_run),
        .out_en         (out_en)
    );

    // Stimulus table: address, data bytes 0..7 (byte 0 in [63:56]), {spread, hiz}.
    localparam logic [7:0]  VA [5] = '{8'hD2, 8'hD3, 8'hD2, 8'hD2, 8'h52};
    localparam logic [63:0] VD [5] = '{
        64'h52A5_C33C_817E_1122,
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0900_0055_AA0F_3344,
        64'h0200_0000_0000_0000};
    localparam logic [1:0]  VX [5] = '{2'b10, 2'b10, 2'b01, 2'b00, 2'b00};

    function automatic logic [7:0] bmask(int k);
        if (k == 0) return 8'h7F;
        if (k == 1) return 8'h0F;
        if (k == 2) return 8'h7F;
        return 8'hFF;
    endfunction

    task automatic model_reset();
        m[0] = 8'h00; m[1] = 8'h0F; m[2] = 8'h7F;
        m[3] = 8'hFF; m[4] = 8'hFF; m[5] = 8'hFF;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic v, logic [7:0] b, logic st, logic sp);
        @(negedge clk);
        byte_vld = v; byte_val = b; frm_start = st; frm_stop = sp;
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic send(logic [7:0] b);
        cyc(1'b1, b, 1'b0, 1'b0);
    endtask

    task automatic check_all(string tag);
        logic [47:0] eq;
        logic [39:0] gates;
        logic        hiz;
        eq    = {m[5], m[4], m[3], m[2], m[1], m[0]};
        gates = {m[5], m[4], m[3], m[2], m[1]};
        hiz   = (m[0][1:0] == 2'b11);
        chk({tag, " R3 reg_q"}, 64'(reg_q), 64'(eq));
        chk({tag, " R6 mode"}, 64'(mode), 64'(m[0][1:0]));
        chk({tag, " R6 spread_en"}, 64'(spread_en), 64'(m[0][1:0] == 2'b10));
        chk({tag, " R7 use_serial_sel"}, 64'(use_serial_sel), 64'(m[0][3]));
        chk({tag, " R7 freq_sel"}, 64'(freq_sel), 64'({m[0][2], m[0][6:4]}));
        chk({tag, " R8 clk_run"}, 64'(clk_run), hiz ? 64'h0 : 64'(gates));
        chk({tag, " R8 out_en"}, 64'(out_en), hiz ? 64'h0 : 64'h00FF_FFFF_7F0F);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", 64'(reg_q), 64'h0000_FFFF_FF7F_0F00);
        check_all("R1 reset");

        // Table-driven full transfers: R2, R3, R5, R6.
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 8'h00, 1'b1, 1'b0);
            send(VA[i]);
            send(8'h00);
            send(8'h08);
            for (int k = 0; k < 8; k++) send(VD[i][63 - 8*k -: 8]);
            cyc(1'b0, 8'h00, 1'b0, 1'b1);
            idle();
            if (VA[i] == 8'hD2)
                for (int k = 0; k < 6; k++) m[k] = VD[i][63 - 8*k -: 8] & bmask(k);
            check_all($sformatf("R2 R5 vector %0d", i));
            chk($sformatf("R6 vector %0d spread", i), 64'(spread_en), 64'(VX[i][1]));
            chk($sformatf("R6 vector %0d hiz", i), 64'(out_en == '0), 64'(VX[i][0]));
        end

        // R9: stop after two data bytes, later strobes without a start ignored.
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        send(8'hD2); send(8'h00); send(8'h00);
        send(8'h00); send(8'h0A);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF);
        idle();
        m[0] = 8'h00; m[1] = 8'h0A;
        check_all("R9 stop mid-transfer");

        // R10: repeated start, new transfer with wrong address.
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        send(8'hD2); send(8'h00); send(8'h00);
        send(8'h02);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        send(8'h10); send(8'h00); send(8'h00); send(8'h03); send(8'hFF);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        idle();
        m[0] = 8'h02;
        check_all("R10 repeated start");

        // R11: byte coinciding with start is dropped, so 0x55 becomes the address.
        cyc(1'b1, 8'hD2, 1'b1, 1'b0);
        send(8'h55); send(8'h00); send(8'h00); send(8'h03); send(8'h00);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        idle();
        check_all("R11 byte with start");

        // R11: byte coinciding with stop is dropped.
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        send(8'hD2); send(8'h00); send(8'h00);
        cyc(1'b1, 8'h03, 1'b0, 1'b1);
        idle();
        check_all("R11 byte with stop");

        // R4: long transfer, no wrap of the byte counter.
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        send(8'hD2); send(8'h00); send(8'h00);
        for (int k = 0; k < 6; k++) send(8'(k + 1));
        for (int k = 0; k < 20; k++) send(8'hFF);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        idle();
        for (int k = 0; k < 6; k++) m[k] = 8'(k + 1) & bmask(k);
        check_all("R4 trailing bytes");
        chk("R6 mode 01 acts normal", 64'(out_en == '0), 64'h0);

        // R1: reset after configuration.
        cyc(1'b0, 8'h00, 1'b0, 1'b0);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        idle();
        model_reset();
        check_all("R1 reset after use");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule